// File: doc/BRIEF.md
# DRAM Bank-Group Command Timing Tracker

This block keeps, for every bank of every rank on one DRAM channel, the earliest controller cycle at which an activate, a column access (read or write) and a precharge may be sent. A scheduler reports each command it sends: its type, rank and bank. From that report the block raises the earliest-issue times of all banks that the command constrains. The scheduler can also ask, in the same cycle, whether a proposed command to a given rank and bank is currently allowed, and gets a one-bit answer with no added latency.

Banks are split into interleaved bank groups. Two commands that land in the same group must be spaced further apart than two that land in different groups. A column access to another rank pays an extra bus turnaround. Each rank also limits how many activates may fall inside a rolling window. Every delay is a parameter counted in controller cycles. Reset clears all history.

Top module: `bg_cmd_timer`

## Requirements
- R1: A bank's group is its bank index modulo `BANK_GROUPS`. With 16 banks and 4 groups, banks 0, 4, 8 and 12 share group 0, and banks 1, 5, 9 and 13 share group 1.
- R2: With `BANK_GROUPS` = 0, each bank is its own group and only the short delays (`T_RRD`, `T_BURST`) apply between banks of a rank.
- R3: An activate to rank r in cycle N keeps every bank of rank r in the same group from a further activate before cycle N+`T_RRD_L`. It keeps the other banks of rank r from one before N+`T_RRD`. Banks of other ranks are not affected.
- R4: An activate to bank b of rank r in cycle N blocks column accesses to that bank before N+`T_RCD` and blocks a precharge to it before N+`T_RAS`.
- R5: A read or write in cycle N blocks further column accesses until a cycle that depends on the target bank. In the same rank and same group that cycle is N+`T_CCD_L`. In the same rank and another group it is N+`T_BURST`. In any other rank it is N+`T_BURST`+`T_CS`. Reads and writes behave the same.
- R6: Each update only raises an earliest-issue time to the larger of its old value and the new bound. A later command with a shorter delay never makes an earlier restriction looser.
- R7: In any rolling span of `T_XAW` cycles, a rank accepts at most `ACT_LIMIT` activates. Once that many fall in the span, the next activate is allowed only from the cycle when the oldest of them is `T_XAW` cycles old. A `T_XAW` of 0 turns this limit off.
- R8: `query_cmd_i` codes are 0 = activate, 1 = read, 2 = write, 3 = precharge. The same codes are used on `issue_cmd_i`. `query_ok_o` is combinational and reflects every command issued in earlier cycles. A command issued in cycle N first constrains the answer in cycle N+1.
- R9: After reset every command to every bank is allowed and the activate window is empty.
- R10: Issuing a precharge changes no earliest-issue time of any bank and does not count as an activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | A command is sent this cycle |
| issue_cmd_i | input | 2 | Type of the sent command (R8 coding) |
| issue_rank_i | input | RANK_W | Rank of the sent command |
| issue_bank_i | input | BANK_W | Bank of the sent command |
| query_cmd_i | input | 2 | Type of the proposed command |
| query_rank_i | input | RANK_W | Rank of the proposed command |
| query_bank_i | input | BANK_W | Bank of the proposed command |
| query_ok_o | output | 1 | Proposed command may be sent this cycle |

## Verification
The assertions assume that the scheduler reports only commands that the block would allow in that cycle, at most one per cycle, and always to a rank and bank that exist. Under that assumption they check the lower bounds that each command places on the timers and that the timers never decrease. The stimulus keeps within the assumption in a simple way. Before each report it asks the block about the same command, and it sends the command only when its own model also finds the command legal. Because the disabled-group configuration is never stricter than the grouped one, a second instance with groups and the window turned off can share the same stimulus.

// File: rtl/bgt_pkg.sv
package bgt_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // interleaved grouping; zero groups means one group per bank
  function automatic int bank_group(int bank, int groups);
    if (groups > 0) return bank % groups;
    return bank;
  endfunction

endpackage

// File: rtl/bgt_bank_timer.sv
module bgt_bank_timer
  import bgt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RANK_W  = 1,
  parameter int BANK_W  = 4,
  parameter int MY_RANK = 0,
  parameter int MY_BANK = 0,
  parameter int GROUPS  = 4,
  parameter int T_BURST = 4,
  parameter int T_CCD_L = 6,
  parameter int T_RRD   = 4,
  parameter int T_RRD_L = 6,
  parameter int T_RCD   = 17,
  parameter int T_RAS   = 39,
  parameter int T_CS    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  now_i,
  input  logic              iss_valid_i,
  input  cmd_e              iss_cmd_i,
  input  logic [RANK_W-1:0] iss_rank_i,
  input  logic [BANK_W-1:0] iss_bank_i,
  input  logic [BANK_W-1:0] iss_grp_i,
  output logic [CNT_W-1:0]  act_at_o,
  output logic [CNT_W-1:0]  col_at_o,
  output logic [CNT_W-1:0]  pre_at_o
);

  localparam bit                GRP_ON    = GROUPS > 0;
  localparam logic [RANK_W-1:0] MY_RANK_V = RANK_W'(MY_RANK);
  localparam logic [BANK_W-1:0] MY_BANK_V = BANK_W'(MY_BANK);
  localparam logic [BANK_W-1:0] MY_GRP_V  = BANK_W'(bank_group(MY_BANK, GROUPS));
  localparam logic [CNT_W-1:0]  RRD_S_V   = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0]  RRD_L_V   = CNT_W'(T_RRD_L);
  localparam logic [CNT_W-1:0]  CCD_S_V   = CNT_W'(T_BURST);
  localparam logic [CNT_W-1:0]  CCD_L_V   = CNT_W'(T_CCD_L);
  localparam logic [CNT_W-1:0]  CCD_X_V   = CNT_W'(T_BURST + T_CS);
  localparam logic [CNT_W-1:0]  RCD_V     = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0]  RAS_V     = CNT_W'(T_RAS);

  logic [CNT_W-1:0] act_q, col_q, pre_q;
  logic [CNT_W-1:0] act_d, col_d, pre_d;
  logic [CNT_W-1:0] act_bnd, col_bnd, rcd_bnd, ras_bnd;
  logic             same_rank, same_bank, grp_long;

  assign same_rank = iss_rank_i == MY_RANK_V;
  assign same_bank = same_rank && (iss_bank_i == MY_BANK_V);
  assign grp_long  = GRP_ON && (iss_grp_i == MY_GRP_V);

  assign act_bnd = now_i + (grp_long ? RRD_L_V : RRD_S_V);
  assign col_bnd = now_i + (!same_rank ? CCD_X_V : (grp_long ? CCD_L_V : CCD_S_V));
  assign rcd_bnd = now_i + RCD_V;
  assign ras_bnd = now_i + RAS_V;

  always_comb begin
    act_d = act_q;
    col_d = col_q;
    pre_d = pre_q;
    if (iss_valid_i) begin
      case (iss_cmd_i)
        CMD_ACT: begin
          if (same_rank && act_bnd > act_q) act_d = act_bnd;
          if (same_bank) begin
            if (rcd_bnd > col_q) col_d = rcd_bnd;
            if (ras_bnd > pre_q) pre_d = ras_bnd;
          end
        end
        CMD_RD, CMD_WR: begin
          if (col_bnd > col_q) col_d = col_bnd;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      col_q <= '0;
      pre_q <= '0;
    end else begin
      act_q <= act_d;
      col_q <= col_d;
      pre_q <= pre_d;
    end
  end

  assign act_at_o = act_q;
  assign col_at_o = col_q;
  assign pre_at_o = pre_q;

endmodule

// File: rtl/bgt_act_window.sv
module bgt_act_window
  import bgt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RANK_W    = 1,
  parameter int MY_RANK   = 0,
  parameter int ACT_LIMIT = 4,
  parameter int T_XAW     = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  now_i,
  input  logic              iss_valid_i,
  input  cmd_e              iss_cmd_i,
  input  logic [RANK_W-1:0] iss_rank_i,
  output logic              ok_o
);

  if (T_XAW == 0) begin : g_off
    logic unused_win;
    assign unused_win = ^{clk_i, rst_ni, now_i, iss_valid_i, iss_cmd_i, iss_rank_i,
                          ACT_LIMIT[0]};
    assign ok_o = 1'b1;
  end else begin : g_on
    localparam logic [RANK_W-1:0] MY_RANK_V = RANK_W'(MY_RANK);
    localparam logic [CNT_W-1:0]  XAW_V     = CNT_W'(T_XAW);

    // newest at index 0, oldest tracked activate at ACT_LIMIT-1
    logic [CNT_W-1:0]     hist_q [ACT_LIMIT];
    logic [ACT_LIMIT-1:0] vld_q;
    logic                 push;

    assign push = iss_valid_i && (iss_cmd_i == CMD_ACT) && (iss_rank_i == MY_RANK_V);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
        for (int i = 0; i < ACT_LIMIT; i++) hist_q[i] <= '0;
      end else if (push) begin
        hist_q[0] <= now_i;
        vld_q[0]  <= 1'b1;
        for (int i = 1; i < ACT_LIMIT; i++) begin
          hist_q[i] <= hist_q[i-1];
          vld_q[i]  <= vld_q[i-1];
        end
      end
    end

    assign ok_o = !vld_q[ACT_LIMIT-1] || (now_i >= hist_q[ACT_LIMIT-1] + XAW_V);
  end

endmodule

// File: rtl/bgt_query_sel.sv
module bgt_query_sel
  import bgt_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int BANKS     = 16,
  parameter int CNT_W     = 32,
  parameter int RANK_W    = 1,
  parameter int BANK_W    = 4
) (
  input  logic [CNT_W-1:0]     now_i,
  input  logic [CNT_W-1:0]     act_at_i [NUM_RANKS][BANKS],
  input  logic [CNT_W-1:0]     col_at_i [NUM_RANKS][BANKS],
  input  logic [CNT_W-1:0]     pre_at_i [NUM_RANKS][BANKS],
  input  logic [NUM_RANKS-1:0] win_ok_i,
  input  cmd_e                 cmd_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic                 ok_o
);

  always_comb begin
    case (cmd_i)
      CMD_ACT: ok_o = (now_i >= act_at_i[rank_i][bank_i]) && win_ok_i[rank_i];
      CMD_RD,
      CMD_WR:  ok_o = now_i >= col_at_i[rank_i][bank_i];
      default: ok_o = now_i >= pre_at_i[rank_i][bank_i];
    endcase
  end

endmodule

// File: rtl/bg_cmd_timer.sv
module bg_cmd_timer
  import bgt_pkg::*;
#(
  parameter int NUM_RANKS   = 2,
  parameter int BANKS       = 16,
  parameter int BANK_GROUPS = 4,
  parameter int CNT_W       = 32,
  parameter int ACT_LIMIT   = 4,
  parameter int T_XAW       = 26,
  parameter int T_BURST     = 4,
  parameter int T_CCD_L     = 6,
  parameter int T_RRD       = 4,
  parameter int T_RRD_L     = 6,
  parameter int T_RCD       = 17,
  parameter int T_RAS       = 39,
  parameter int T_CS        = 2,
  localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_cmd_i,
  input  logic [RANK_W-1:0] issue_rank_i,
  input  logic [BANK_W-1:0] issue_bank_i,
  input  logic [1:0]        query_cmd_i,
  input  logic [RANK_W-1:0] query_rank_i,
  input  logic [BANK_W-1:0] query_bank_i,
  output logic              query_ok_o
);

  if (BANK_GROUPS > 0) begin : g_cfg
    if ((T_CCD_L <= T_BURST) || (T_RRD_L <= T_RRD) ||
        (BANK_GROUPS > BANKS) || ((BANKS % BANK_GROUPS) != 0)) begin : g_bad
      $error("bg_cmd_timer: illegal bank-group timing configuration");
    end
  end

  logic [CNT_W-1:0]     now_q;
  cmd_e                 iss_cmd;
  logic [BANK_W-1:0]    iss_grp;
  logic [CNT_W-1:0]     act_at [NUM_RANKS][BANKS];
  logic [CNT_W-1:0]     col_at [NUM_RANKS][BANKS];
  logic [CNT_W-1:0]     pre_at [NUM_RANKS][BANKS];
  logic [NUM_RANKS-1:0] win_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  assign iss_cmd = cmd_e'(issue_cmd_i);

  if (BANK_GROUPS > 0) begin : g_grp
    assign iss_grp = BANK_W'(issue_bank_i % BANK_W'(BANK_GROUPS));
  end else begin : g_flat
    assign iss_grp = issue_bank_i;
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    bgt_act_window #(
      .CNT_W(CNT_W), .RANK_W(RANK_W), .MY_RANK(r),
      .ACT_LIMIT(ACT_LIMIT), .T_XAW(T_XAW)
    ) u_win (
      .clk_i, .rst_ni, .now_i(now_q),
      .iss_valid_i(issue_valid_i), .iss_cmd_i(iss_cmd), .iss_rank_i(issue_rank_i),
      .ok_o(win_ok[r])
    );
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      bgt_bank_timer #(
        .CNT_W(CNT_W), .RANK_W(RANK_W), .BANK_W(BANK_W),
        .MY_RANK(r), .MY_BANK(b), .GROUPS(BANK_GROUPS),
        .T_BURST(T_BURST), .T_CCD_L(T_CCD_L), .T_RRD(T_RRD), .T_RRD_L(T_RRD_L),
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_CS(T_CS)
      ) u_tmr (
        .clk_i, .rst_ni, .now_i(now_q),
        .iss_valid_i(issue_valid_i), .iss_cmd_i(iss_cmd),
        .iss_rank_i(issue_rank_i), .iss_bank_i(issue_bank_i), .iss_grp_i(iss_grp),
        .act_at_o(act_at[r][b]), .col_at_o(col_at[r][b]), .pre_at_o(pre_at[r][b])
      );
    end
  end

  bgt_query_sel #(
    .NUM_RANKS(NUM_RANKS), .BANKS(BANKS), .CNT_W(CNT_W),
    .RANK_W(RANK_W), .BANK_W(BANK_W)
  ) u_sel (
    .now_i(now_q), .act_at_i(act_at), .col_at_i(col_at), .pre_at_i(pre_at),
    .win_ok_i(win_ok), .cmd_i(cmd_e'(query_cmd_i)),
    .rank_i(query_rank_i), .bank_i(query_bank_i), .ok_o(query_ok_o)
  );

endmodule

// File: rtl/bgt_checker.sv
module bgt_checker
  import bgt_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int BANKS     = 16,
  parameter int GROUPS    = 4,
  parameter int CNT_W     = 32,
  parameter int T_BURST   = 4,
  parameter int T_RRD     = 4,
  parameter int T_RRD_L   = 6,
  parameter int T_RCD     = 17,
  parameter int T_RAS     = 39,
  parameter int T_CS      = 2,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_valid_i,
  input logic [1:0]        issue_cmd_i,
  input logic [RANK_W-1:0] issue_rank_i,
  input logic [BANK_W-1:0] issue_bank_i,
  input logic [CNT_W-1:0]  now_i,
  input logic [CNT_W-1:0]  act_at_i [NUM_RANKS][BANKS],
  input logic [CNT_W-1:0]  col_at_i [NUM_RANKS][BANKS],
  input logic [CNT_W-1:0]  pre_at_i [NUM_RANKS][BANKS]
);

  logic is_act, is_col, is_pre;
  assign is_act = issue_valid_i && (issue_cmd_i == CMD_ACT);
  assign is_col = issue_valid_i && ((issue_cmd_i == CMD_RD) || (issue_cmd_i == CMD_WR));
  assign is_pre = issue_valid_i && (issue_cmd_i == CMD_PRE);

  // input assumption: the scheduler only sends what is allowed now (R8)
  p_legal_act_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> now_i >= act_at_i[issue_rank_i][issue_bank_i]);
  p_legal_col_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> now_i >= col_at_i[issue_rank_i][issue_bank_i]);
  p_legal_pre_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> now_i >= pre_at_i[issue_rank_i][issue_bank_i]);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_r
    for (genvar b = 0; b < BANKS; b++) begin : g_b
      localparam int G = bank_group(b, GROUPS);

      p_timer_mono_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_at_i[r][b] >= $past(act_at_i[r][b])) &&
        (col_at_i[r][b] >= $past(col_at_i[r][b])) &&
        (pre_at_i[r][b] >= $past(pre_at_i[r][b])));

      p_act_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_act && issue_rank_i == RANK_W'(r))
        |=> act_at_i[r][b] >= $past(now_i) + CNT_W'(T_RRD));

      if (GROUPS > 0) begin : g_long
        p_act_long_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (is_act && issue_rank_i == RANK_W'(r) &&
           bank_group(int'(issue_bank_i), GROUPS) == G)
          |=> act_at_i[r][b] >= $past(now_i) + CNT_W'(T_RRD_L));
      end

      p_act_rcd_ras_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_act && issue_rank_i == RANK_W'(r) && issue_bank_i == BANK_W'(b))
        |=> (col_at_i[r][b] >= $past(now_i) + CNT_W'(T_RCD)) &&
            (pre_at_i[r][b] >= $past(now_i) + CNT_W'(T_RAS)));

      p_col_rank_sw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_col && issue_rank_i != RANK_W'(r))
        |=> col_at_i[r][b] >= $past(now_i) + CNT_W'(T_BURST + T_CS));

      p_pre_no_effect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_pre && $past(!issue_valid_i))
        |=> $stable(act_at_i[r][b]) && $stable(col_at_i[r][b]));
    end
  end

endmodule

bind bg_cmd_timer bgt_checker #(
  .NUM_RANKS(NUM_RANKS), .BANKS(BANKS), .GROUPS(BANK_GROUPS), .CNT_W(CNT_W),
  .T_BURST(T_BURST), .T_RRD(T_RRD), .T_RRD_L(T_RRD_L),
  .T_RCD(T_RCD), .T_RAS(T_RAS), .T_CS(T_CS)
) u_chk (
  .clk_i, .rst_ni, .issue_valid_i, .issue_cmd_i, .issue_rank_i, .issue_bank_i,
  .now_i(now_q), .act_at_i(act_at), .col_at_i(col_at), .pre_at_i(pre_at)
);

// File: tb/bg_cmd_timer_test.sv
`timescale 1ns/1ps
module bg_cmd_timer_test;

  localparam int C_ACT = 0, C_RD = 1, C_WR = 2, C_PRE = 3;
  localparam int NR = 2, NB = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       issue_valid = 1'b0;
  logic [1:0] issue_cmd = '0;
  logic       issue_rank = '0;
  logic [3:0] issue_bank = '0;
  logic [1:0] query_cmd = '0;
  logic       query_rank = '0;
  logic [3:0] query_bank = '0;
  logic       query_ok, query_ok_ng;

  always #10 clk = ~clk;

  bg_cmd_timer uut (
    .clk_i(clk), .rst_ni, .issue_valid_i(issue_valid), .issue_cmd_i(issue_cmd),
    .issue_rank_i(issue_rank), .issue_bank_i(issue_bank),
    .query_cmd_i(query_cmd), .query_rank_i(query_rank), .query_bank_i(query_bank),
    .query_ok_o(query_ok)
  );

  // groups and activate window disabled
  bg_cmd_timer #(.BANK_GROUPS(0), .T_XAW(0)) uut_ng (
    .clk_i(clk), .rst_ni, .issue_valid_i(issue_valid), .issue_cmd_i(issue_cmd),
    .issue_rank_i(issue_rank), .issue_bank_i(issue_bank),
    .query_cmd_i(query_cmd), .query_rank_i(query_rank), .query_bank_i(query_bank),
    .query_ok_o(query_ok_ng)
  );

  // reference model: index 0 grouped, 1 flat
  int act_t [2][NR][NB];
  int col_t [2][NR][NB];
  int pre_t [2][NR][NB];
  int wq [NR][$];
  int now_c = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic int grp(int m, int b);
    return (m == 0) ? b % 4 : b;
  endfunction

  function automatic bit win_ok(int r);
    int n = 0;
    foreach (wq[r][i]) if (now_c < wq[r][i] + 26) n++;
    return n < 4;
  endfunction

  function automatic bit legal(int m, int c, int r, int b);
    case (c)
      C_ACT:   return (now_c >= act_t[m][r][b]) && (m == 1 || win_ok(r));
      C_RD,
      C_WR:    return now_c >= col_t[m][r][b];
      default: return now_c >= pre_t[m][r][b];
    endcase
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_issue(int c, int r, int b);
    for (int m = 0; m < 2; m++) begin
      if (c == C_ACT) begin
        for (int bb = 0; bb < NB; bb++) begin
          int d = (m == 0 && grp(m, bb) == grp(m, b)) ? 6 : 4;
          act_t[m][r][bb] = imax(act_t[m][r][bb], now_c + d);
        end
        col_t[m][r][b] = imax(col_t[m][r][b], now_c + 17);
        pre_t[m][r][b] = imax(pre_t[m][r][b], now_c + 39);
      end else if (c == C_RD || c == C_WR) begin
        for (int rr = 0; rr < NR; rr++)
          for (int bb = 0; bb < NB; bb++) begin
            int d = (rr != r) ? 6 : ((m == 0 && grp(m, bb) == grp(m, b)) ? 6 : 4);
            col_t[m][rr][bb] = imax(col_t[m][rr][bb], now_c + d);
          end
      end
    end
    if (c == C_ACT) begin
      while (wq[r].size() > 0 && wq[r][0] + 26 <= now_c) void'(wq[r].pop_front());
      wq[r].push_back(now_c);
    end
  endtask

  task automatic check(logic act, logic exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, now_c, act, exp);
    end
  endtask

  // one cycle: query (and optionally send) c/r/b, compare, advance
  task automatic step(int c, int r, int b, bit want, string tag, int lit, int lit_ng);
    bit do_iss;
    do_iss      = want && legal(0, c, r, b);
    query_cmd   = 2'(c);
    query_rank  = 1'(r);
    query_bank  = 4'(b);
    issue_cmd   = 2'(c);
    issue_rank  = 1'(r);
    issue_bank  = 4'(b);
    issue_valid = do_iss;
    #1;
    check(query_ok, legal(0, c, r, b), tag);
    check(query_ok_ng, legal(1, c, r, b), {tag, " flat"});
    if (lit >= 0)    check(query_ok, lit[0], {tag, " fixed"});
    if (lit_ng >= 0) check(query_ok_ng, lit_ng[0], {tag, " flat fixed"});
    @(posedge clk);
    if (do_iss) model_issue(c, r, b);
    now_c++;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic wait_to(int t);
    while (now_c < t) step(C_RD, 0, 15, 0, "R8 idle", -1, -1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t3, t4;
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < NR; r++)
        for (int b = 0; b < NB; b++) begin
          act_t[m][r][b] = 0; col_t[m][r][b] = 0; pre_t[m][r][b] = 0;
        end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R9: all allowed out of reset
    step(C_ACT, 0, 0, 0, "R9", 1, 1);
    step(C_RD, 1, 15, 0, "R9", 1, 1);
    step(C_PRE, 0, 3, 0, "R9", 1, 1);

    // R3 / R1 / R2: activate spacing
    t0 = now_c;
    step(C_ACT, 0, 0, 1, "R3", 1, 1);
    step(C_ACT, 0, 4, 0, "R3", 0, 0);
    step(C_ACT, 1, 0, 0, "R3", 1, 1);
    wait_to(t0 + 3);
    step(C_ACT, 0, 1, 0, "R3", 0, 0);
    step(C_ACT, 0, 4, 0, "R2", 0, 1);
    step(C_ACT, 0, 12, 0, "R1", 0, 1);
    step(C_ACT, 0, 8, 0, "R1", 1, 1);
    step(C_ACT, 0, 1, 0, "R3", 1, 1);

    // R4: row-to-column and row-active minimums
    wait_to(t0 + 16);
    step(C_RD, 0, 0, 0, "R4", 0, 0);
    step(C_WR, 0, 0, 0, "R4", 1, 1);
    wait_to(t0 + 38);
    step(C_PRE, 0, 0, 0, "R4", 0, 0);
    step(C_PRE, 0, 0, 0, "R4", 1, 1);

    // R5: column spacing
    t1 = now_c;
    step(C_RD, 0, 0, 1, "R5", 1, 1);
    step(C_RD, 1, 0, 0, "R5", 0, 0);
    wait_to(t1 + 3);
    step(C_WR, 0, 1, 0, "R5", 0, 0);
    step(C_WR, 0, 1, 0, "R5", 1, 1);
    step(C_RD, 0, 4, 0, "R5", 0, 1);
    step(C_RD, 1, 0, 0, "R5", 1, 1);

    // R10: precharge leaves timers alone
    step(C_PRE, 0, 1, 1, "R10", 1, 1);
    step(C_RD, 0, 1, 0, "R10", 1, 1);
    step(C_ACT, 0, 1, 0, "R10", 1, 1);

    // R7: activate window on rank 1
    t3 = now_c;
    step(C_ACT, 1, 0, 1, "R7", 1, 1);
    wait_to(t3 + 4);
    step(C_ACT, 1, 1, 1, "R7", 1, 1);
    wait_to(t3 + 8);
    step(C_ACT, 1, 2, 1, "R7", 1, 1);
    wait_to(t3 + 12);
    step(C_ACT, 1, 3, 1, "R7", 1, 1);
    wait_to(t3 + 16);
    step(C_ACT, 1, 5, 0, "R7", 0, 1);
    wait_to(t3 + 25);
    step(C_ACT, 1, 5, 0, "R7", 0, 1);
    step(C_ACT, 1, 5, 0, "R7", 1, 1);

    // R6: later short bound does not loosen earlier long one
    wait_to(now_c + 30);
    t4 = now_c;
    step(C_ACT, 0, 2, 1, "R6", 1, 1);
    step(C_RD, 0, 3, 1, "R6", 1, 1);
    wait_to(t4 + 5);
    step(C_RD, 0, 2, 0, "R6", 0, 0);
    wait_to(t4 + 17);
    step(C_RD, 0, 2, 0, "R6", 1, 1);

    // R8: mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int c = $urandom_range(3, 0);
      int r = $urandom_range(1, 0);
      int b = $urandom_range(15, 0);
      bit w = ($urandom_range(1, 0) == 1);
      step(c, r, b, w, "R8", -1, -1);
    end

    finish_run();
  end

endmodule